// File: doc/BRIEF.md
# Sleep-on-exit power state controller

This block decides when a small processor core stops its clock and when it restarts it. The core reports four kinds of completion pulse: handler return, subroutine return, return from debug, and data barrier. The core can also issue an explicit wait-for-interrupt or wait-for-event request. Each completion pulse has its own enable bit. When a pulse is enabled, the controller puts the core to sleep by itself, and no sleep instruction is needed. Sleep after a barrier can be held off until the write buffer reports empty.

While the core sleeps, the controller watches the pending-interrupt vector through a per-line mask and watches the event input. It restarts the clock through a waking phase whose length depends on the sleep depth. A sleep of the wait-for-event kind drops straight back into sleep if nothing is left to do when the waking phase ends. A 7-bit configuration word holds the trigger enables, the drain-wait bit, the depth and the sleep kind. A write to this word is applied only while the core is active. A write that arrives at any other time is held until the core is active again.

Top module: `sleep_exit_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (active), `clk_en_o` is 1, and `deep_sleep_o` and `wake_pulse_o` are 0. The configuration word is all zero, so no completion pulse starts a sleep.
- R2: Configuration bit 0 enables sleep on a handler-return pulse. When the bit is 0, the pulse is ignored and the state stays 0.
- R3: Bit 1 enables sleep on a subroutine-return pulse and bit 2 enables sleep on a debug-return pulse. Each pulse is ignored when its own bit is 0, whatever the other bits hold.
- R4: Bit 3 enables sleep on a barrier pulse. When bit 4 (drain wait) is also 1 and `wbuf_empty_i` is 0, the state goes to 1 (drain wait) and stays there until `wbuf_empty_i` is 1, and then it goes to sleep. An unmasked interrupt during drain wait returns the state to 0. Triggers other than the barrier never wait for the drain.
- R5: Bit 5 selects the depth. When it is 0, sleep is state 2 and `deep_sleep_o` is 0. When it is 1, sleep is state 3 and `deep_sleep_o` is 1.
- R6: `clk_en_o` is 0 in exactly the cycles where the state is 2 or 3. It is 1 from the first cycle of waking (state 4).
- R7: A sleep of the wait-for-interrupt kind is left only when some line has `irq_pend_i` set and `irq_mask_i` clear. A masked line and the event input do not wake it.
- R8: Waking (state 4) lasts 1 cycle after a shallow sleep and DEEP_WAKE_CYC cycles after a deep sleep. Then the state is 0 and `wake_pulse_o` is 1 for that one first active cycle.
- R9: Bit 6 set to 1 makes the automatic triggers enter a sleep of the wait-for-event kind. Such a sleep also wakes on an event. At the end of waking it returns to the same sleep state, without `wake_pulse_o`, if no event is latched and no unmasked interrupt is pending.
- R10: An event that arrives while awake sets a one-bit latch. A later wait-for-event trigger clears the latch and the state stays 0.
- R11: A trigger that arrives while an unmasked interrupt is pending is skipped, and the state stays 0.
- R12: A configuration write made while the state is not 0 leaves the current sleep unchanged. It is held, with the last write winning, and is applied on the first active cycle.
- R13: `wfi_req_i` and `wfe_req_i` start a sleep whatever the enable bits hold. When both are raised together, `wfi_req_i` wins and the sleep is of the wait-for-interrupt kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word: [3:0] trigger enables, [4] drain wait, [5] deep, [6] wait-for-event kind |
| hdl_ret_i | input | 1 | Handler-return pulse |
| sub_ret_i | input | 1 | Subroutine-return pulse |
| dbg_ret_i | input | 1 | Debug-return pulse |
| dbar_i | input | 1 | Data-barrier pulse |
| wfi_req_i | input | 1 | Explicit wait-for-interrupt request |
| wfe_req_i | input | 1 | Explicit wait-for-event request |
| wbuf_empty_i | input | 1 | Write buffer empty |
| irq_pend_i | input | N_IRQ | Pending interrupt lines |
| irq_mask_i | input | N_IRQ | Per-line mask, 1 blocks wakeup |
| event_i | input | 1 | Event input |
| clk_en_o | output | 1 | Core clock-gate enable |
| deep_sleep_o | output | 1 | High while in deep sleep |
| wake_pulse_o | output | 1 | One-cycle pulse on return to active |
| state_o | output | 3 | 0 active, 1 drain wait, 2 shallow, 3 deep, 4 waking |

## Verification
Every input is sampled on a rising edge, and each state decision appears on `state_o` one cycle later. `clk_en_o` and `deep_sleep_o` follow the state in the same cycle. `wake_pulse_o` rises one cycle after the last waking cycle. A held configuration write is applied at the edge that ends the first active cycle, so it first governs a trigger in the second active cycle. The bench drives inputs 1 ns after an edge and reads outputs 1 ns after the next edge. Waking length is measured by counting the cycles in which the state reads 4. Triggers are also sampled only after the bench has waited out the first active cycle.

// File: rtl/sleep_exit_pkg.sv
package sleep_exit_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_SLP_SH = 3'd2,
    ST_SLP_DP = 3'd3,
    ST_WAKING = 3'd4
  } pwr_state_e;

  localparam int N_TRIG   = 4;
  localparam int TRIG_BAR = 3;

  // packed MSB first: bit 6 kind, bit 5 deep, bit 4 drain wait, bits 3:0 enables
  typedef struct packed {
    logic              wfe_kind;
    logic              deep;
    logic              drain_wait;
    logic [N_TRIG-1:0] trig_en;
  } slp_cfg_t;

  localparam int CFG_W = $bits(slp_cfg_t);

endpackage

// File: rtl/sleep_cfg_hold.sv
module sleep_cfg_hold
  import sleep_exit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  slp_cfg_t wr_data,
  input  logic     open_i,
  output slp_cfg_t cfg_o
);

  slp_cfg_t cfg_q, cfg_d, held_q, held_d;
  logic     held_v_q, held_v_d;
  logic     cfg_ld, held_ld;

  always_comb begin
    cfg_d    = cfg_q;
    cfg_ld   = 1'b0;
    held_d   = held_q;
    held_v_d = held_v_q;
    held_ld  = 1'b0;
    if (open_i) begin
      if (wr_en) begin
        cfg_d  = wr_data;
        cfg_ld = 1'b1;
      end else if (held_v_q) begin
        cfg_d  = held_q;
        cfg_ld = 1'b1;
      end
      held_v_d = 1'b0;
      held_ld  = held_v_q;
    end else if (wr_en) begin
      held_d   = wr_data;
      held_v_d = 1'b1;
      held_ld  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_ld) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else if (held_ld) begin
      held_q   <= held_d;
      held_v_q <= held_v_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/sleep_trig_decode.sv
module sleep_trig_decode
  import sleep_exit_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  slp_cfg_t          cfg_i,
  input  logic [N_TRIG-1:0] pulse_i,
  input  logic              wfi_req_i,
  input  logic              wfe_req_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_IRQ-1:0]  irq_mask_i,
  output logic              trig_any_o,
  output logic              trig_wfe_o,
  output logic              trig_drain_o,
  output logic              irq_hit_o
);

  logic [N_TRIG-1:0] hit;

  for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
    assign hit[t] = pulse_i[t] & cfg_i.trig_en[t];
  end

  always_comb begin
    trig_any_o   = wfi_req_i | wfe_req_i | (|hit);
    if (wfi_req_i) begin
      trig_wfe_o = 1'b0;
    end else if (wfe_req_i) begin
      trig_wfe_o = 1'b1;
    end else begin
      trig_wfe_o = cfg_i.wfe_kind;
    end
    trig_drain_o = hit[TRIG_BAR] & cfg_i.drain_wait;
    irq_hit_o    = |(irq_pend_i & ~irq_mask_i);
  end

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_exit_pkg::*;
#(
  parameter int DEEP_WAKE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_deep_i,
  input  logic       trig_any_i,
  input  logic       trig_wfe_i,
  input  logic       trig_drain_i,
  input  logic       irq_hit_i,
  input  logic       wbuf_empty_i,
  input  logic       event_i,
  output pwr_state_e state_o,
  output logic       wake_pulse_o
);

  localparam int CNT_W = $clog2(DEEP_WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] DEEP_LOAD = CNT_W'(DEEP_WAKE_CYC - 1);

  pwr_state_e       state_q, state_d;
  logic             kind_q, kind_d;
  logic             deep_q, deep_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ev_q, ev_d, ev_clr;
  logic             wake_q, wake_d;
  logic             ev_wake;
  logic             entry_ld;

  assign ev_wake = ev_q | event_i;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    deep_d   = deep_q;
    cnt_d    = cnt_q;
    ev_clr   = 1'b0;
    wake_d   = 1'b0;
    entry_ld = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (trig_any_i && !irq_hit_i) begin
          if (trig_wfe_i && ev_q) begin
            ev_clr = 1'b1;
          end else begin
            entry_ld = 1'b1;
            kind_d   = trig_wfe_i;
            deep_d   = cfg_deep_i;
            if (trig_drain_i && !wbuf_empty_i) begin
              state_d = ST_DRAIN;
            end else begin
              state_d = cfg_deep_i ? ST_SLP_DP : ST_SLP_SH;
            end
          end
        end
      end
      ST_DRAIN: begin
        if (irq_hit_i) begin
          state_d = ST_ACTIVE;
        end else if (wbuf_empty_i) begin
          state_d = deep_q ? ST_SLP_DP : ST_SLP_SH;
        end
      end
      ST_SLP_SH, ST_SLP_DP: begin
        if (irq_hit_i || (kind_q && ev_wake)) begin
          state_d = ST_WAKING;
          cnt_d   = deep_q ? DEEP_LOAD : '0;
        end
      end
      ST_WAKING: begin
        if (cnt_q == '0) begin
          if (kind_q && !ev_wake && !irq_hit_i) begin
            state_d = deep_q ? ST_SLP_DP : ST_SLP_SH;
          end else begin
            state_d = ST_ACTIVE;
            wake_d  = 1'b1;
            ev_clr  = kind_q;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
    ev_d = (ev_q & ~ev_clr) | event_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      ev_q    <= 1'b0;
      wake_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      ev_q    <= ev_d;
      wake_q  <= wake_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= 1'b0;
      deep_q <= 1'b0;
    end else if (entry_ld) begin
      kind_q <= kind_d;
      deep_q <= deep_d;
    end
  end

  assign state_o      = state_q;
  assign wake_pulse_o = wake_q;

endmodule

// File: rtl/sleep_exit_ctrl.sv
module sleep_exit_ctrl
  import sleep_exit_pkg::*;
#(
  parameter int N_IRQ         = 8,
  parameter int DEEP_WAKE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [6:0]       cfg_wdata,
  input  logic             hdl_ret_i,
  input  logic             sub_ret_i,
  input  logic             dbg_ret_i,
  input  logic             dbar_i,
  input  logic             wfi_req_i,
  input  logic             wfe_req_i,
  input  logic             wbuf_empty_i,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_IRQ-1:0] irq_mask_i,
  input  logic             event_i,
  output logic             clk_en_o,
  output logic             deep_sleep_o,
  output logic             wake_pulse_o,
  output logic [2:0]       state_o
);

  logic [1:0]  rst_sync_q;
  logic        rst_sync_n;
  slp_cfg_t    cfg;
  pwr_state_e  state;
  logic        trig_any, trig_wfe, trig_drain, irq_hit;
  logic [N_TRIG-1:0] pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign pulses = {dbar_i, dbg_ret_i, sub_ret_i, hdl_ret_i};

  sleep_cfg_hold u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_data (slp_cfg_t'(cfg_wdata)),
    .open_i  (state == ST_ACTIVE),
    .cfg_o   (cfg)
  );

  sleep_trig_decode #(.N_IRQ(N_IRQ)) u_dec (
    .cfg_i        (cfg),
    .pulse_i      (pulses),
    .wfi_req_i    (wfi_req_i),
    .wfe_req_i    (wfe_req_i),
    .irq_pend_i   (irq_pend_i),
    .irq_mask_i   (irq_mask_i),
    .trig_any_o   (trig_any),
    .trig_wfe_o   (trig_wfe),
    .trig_drain_o (trig_drain),
    .irq_hit_o    (irq_hit)
  );

  sleep_fsm #(.DEEP_WAKE_CYC(DEEP_WAKE_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_deep_i   (cfg.deep),
    .trig_any_i   (trig_any),
    .trig_wfe_i   (trig_wfe),
    .trig_drain_i (trig_drain),
    .irq_hit_i    (irq_hit),
    .wbuf_empty_i (wbuf_empty_i),
    .event_i      (event_i),
    .state_o      (state),
    .wake_pulse_o (wake_pulse_o)
  );

  assign clk_en_o     = !((state == ST_SLP_SH) || (state == ST_SLP_DP));
  assign deep_sleep_o = (state == ST_SLP_DP);
  assign state_o      = state;

endmodule

// File: rtl/sleep_exit_chk.sv
module sleep_exit_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state_i,
  input logic             clk_en,
  input logic             deep_sleep,
  input logic             wake_pulse,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_mask,
  input logic             wbuf_empty
);

  logic unmasked;
  logic asleep;
  assign unmasked = |(irq_pend & ~irq_mask);
  assign asleep   = (state_i == 3'd2) || (state_i == 3'd3);

  // R6
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !clk_en);

  // R6
  waking_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == 3'd4) |-> clk_en);

  // R5
  depth_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> (state_i == 3'd3));

  // R8
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (state_i == 3'd0) && ($past(state_i) == 3'd4));

  // R11
  irq_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_i == 3'd0) && unmasked) |=> (state_i == 3'd0));

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_i == 3'd1) && !wbuf_empty && !unmasked) |=> (state_i == 3'd1));

  // R7
  sleep_exit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> ((state_i == $past(state_i)) || (state_i == 3'd4)));

endmodule

bind sleep_exit_ctrl sleep_exit_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .state_i    (state_o),
  .clk_en     (clk_en_o),
  .deep_sleep (deep_sleep_o),
  .wake_pulse (wake_pulse_o),
  .irq_pend   (irq_pend_i),
  .irq_mask   (irq_mask_i),
  .wbuf_empty (wbuf_empty_i)
);

// File: tb/sleep_exit_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_exit_ctrl_tb;

  localparam int NI = 8;
  localparam int DW = 8;

  logic          clk, rst_n, cfg_we;
  logic [6:0]    cfg_wdata;
  logic [3:0]    trig_v;
  logic          wfi_req, wfe_req, wbuf_empty, event_in;
  logic [NI-1:0] irq_pend, irq_mask;
  logic          clk_en, deep_sleep, wake_pulse;
  logic [2:0]    state;
  int            n_chk, n_fail;
  bit            done;

  sleep_exit_ctrl #(.N_IRQ(NI), .DEEP_WAKE_CYC(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hdl_ret_i(trig_v[0]), .sub_ret_i(trig_v[1]), .dbg_ret_i(trig_v[2]),
    .dbar_i(trig_v[3]), .wfi_req_i(wfi_req), .wfe_req_i(wfe_req),
    .wbuf_empty_i(wbuf_empty), .irq_pend_i(irq_pend), .irq_mask_i(irq_mask),
    .event_i(event_in), .clk_en_o(clk_en), .deep_sleep_o(deep_sleep),
    .wake_pulse_o(wake_pulse), .state_o(state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [6:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig(input int t);
    trig_v[t] = 1'b1;
    tick();
    trig_v = '0;
  endtask

  task automatic irq_blip();
    irq_pend[0] = 1'b1;
    tick();
    irq_pend[0] = 1'b0;
  endtask

  task automatic pulse_event();
    event_in = 1'b1;
    tick();
    event_in = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; trig_v = '0;
    wfi_req = 1'b0; wfe_req = 1'b0; wbuf_empty = 1'b1; event_in = 1'b0;
    irq_pend = '0; irq_mask = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset values and all-off configuration
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 deep", deep_sleep, 0);
    chk("R1 wake", wake_pulse, 0);
    trig_v = 4'hF; tick(); trig_v = '0;
    chk("R1 all triggers off", state, 0);

    // R7 wait-for-interrupt sleep ignores masked lines and events
    wr_cfg(7'h01);
    pulse_trig(0);
    chk("R2 sleep", state, 2);
    chk("R6 gate low", clk_en, 0);
    chk("R5 shallow flag", deep_sleep, 0);
    irq_mask[0] = 1'b1; irq_pend[0] = 1'b1;
    tick(); tick();
    chk("R7 masked", state, 2);
    pulse_event();
    chk("R7 event ignored", state, 2);
    irq_mask[0] = 1'b0;
    tick();
    chk("R8 waking", state, 4);
    chk("R6 gate high in waking", clk_en, 1);
    irq_pend[0] = 1'b0;
    tick();
    chk("R8 active", state, 0);
    chk("R8 wake pulse", wake_pulse, 1);
    tick();
    chk("R8 pulse one cycle", wake_pulse, 0);

    // R10 latched event consumed by wait-for-event request
    wfe_req = 1'b1; tick(); wfe_req = 1'b0;
    chk("R10 skip", state, 0);
    wfe_req = 1'b1; tick(); wfe_req = 1'b0;
    chk("R13 wfe enters", state, 2);
    pulse_event();
    chk("R9 event wakes", state, 4);
    tick();
    chk("R9 active", state, 0);
    chk("R9 wake pulse", wake_pulse, 1);

    // R2 R3 R4 sweep: each trigger against its own bit, others on
    for (int t = 0; t < 4; t++) begin
      for (int en = 0; en < 2; en++) begin
        logic [3:0] m;
        string tg;
        m  = (en != 0) ? 4'(1 << t) : 4'(~(1 << t));
        tg = (t == 0) ? "R2" : ((t == 3) ? "R4" : "R3");
        wr_cfg({3'b000, m});
        tick();
        pulse_trig(t);
        chk(tg, state, (en != 0) ? 2 : 0);
        if (en != 0) begin
          irq_blip();
          tick();
          chk(tg, state, 0);
        end
      end
    end

    // R5 R8 deep sleep and waking length
    wr_cfg(7'h21);
    pulse_trig(0);
    chk("R5 deep state", state, 3);
    chk("R5 deep flag", deep_sleep, 1);
    chk("R6 deep gate", clk_en, 0);
    irq_blip();
    begin
      int n;
      n = (state == 4) ? 1 : 0;
      while (state == 4 && n < 40) begin
        tick();
        if (state == 4) n++;
      end
      chk("R8 deep waking cycles", n, DW);
    end
    chk("R8 deep active", state, 0);
    chk("R8 deep pulse", wake_pulse, 1);

    // R4 drain wait
    wr_cfg(7'h18);
    wbuf_empty = 1'b0;
    pulse_trig(3);
    chk("R4 drain", state, 1);
    repeat (3) tick();
    chk("R4 drain hold", state, 1);
    wbuf_empty = 1'b1;
    tick();
    chk("R4 drained", state, 2);
    irq_blip(); tick();
    wbuf_empty = 1'b0;
    pulse_trig(3);
    chk("R4 drain again", state, 1);
    irq_blip();
    chk("R4 irq aborts", state, 0);
    wr_cfg(7'h19);
    pulse_trig(0);
    chk("R4 non-barrier no wait", state, 2);
    irq_blip(); tick();
    wbuf_empty = 1'b1;

    // R11 pending unmasked interrupt skips the sleep
    wr_cfg(7'h01);
    irq_pend[2] = 1'b1;
    pulse_trig(0);
    chk("R11 skip auto", state, 0);
    wfi_req = 1'b1; tick(); wfi_req = 1'b0;
    chk("R11 skip explicit", state, 0);
    irq_mask[2] = 1'b1;
    pulse_trig(0);
    chk("R11 masked does not skip", state, 2);
    irq_mask[2] = 1'b0;
    tick();
    chk("R7 unmask wakes", state, 4);
    irq_pend[2] = 1'b0;
    tick();

    // R7 per-line mask sweep
    for (int i = 0; i < NI; i++) begin
      irq_pend = '0; irq_mask = '0;
      pulse_trig(0);
      irq_pend = NI'(1 << i); irq_mask = NI'(1 << i);
      tick();
      chk("R7 line masked", state, 2);
      irq_mask = '0;
      tick();
      chk("R7 line unmasked", state, 4);
      irq_pend = '0;
      tick();
      chk("R7 line back", state, 0);
    end

    // R9 re-entry of a wait-for-event sleep
    wr_cfg(7'h41);
    pulse_trig(0);
    chk("R9 wfe sleep", state, 2);
    irq_blip();
    chk("R9 waking", state, 4);
    tick();
    chk("R9 re-enter", state, 2);
    chk("R9 no pulse", wake_pulse, 0);
    tick();
    chk("R9 stays", state, 2);
    pulse_event();
    chk("R9 event wakes", state, 4);
    tick();
    chk("R9 leaves", state, 0);

    // R13 explicit requests, wfi wins
    wr_cfg(7'h00);
    wfi_req = 1'b1; wfe_req = 1'b1; tick(); wfi_req = 1'b0; wfe_req = 1'b0;
    chk("R13 explicit sleep", state, 2);
    pulse_event();
    chk("R13 wfi kind ignores event", state, 2);
    irq_blip(); tick();
    chk("R13 back", state, 0);
    wfe_req = 1'b1; tick(); wfe_req = 1'b0;
    chk("R10 consume", state, 0);

    // R12 writes held while asleep, last one wins
    wr_cfg(7'h01);
    pulse_trig(0);
    wr_cfg(7'h00);
    wr_cfg(7'h22);
    chk("R12 sleep unchanged", state, 2);
    irq_blip();
    tick();
    chk("R12 shallow wake", state, 0);
    tick();
    pulse_trig(0);
    chk("R12 old enable gone", state, 0);
    pulse_trig(1);
    chk("R12 new cfg deep", state, 3);
    irq_blip();
    repeat (DW) tick();
    chk("R12 back", state, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule